// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Shortened Final Stop Bit

The block sends bytes as asynchronous serial frames on a line that rests high. A bit lasts a fixed number of pulses on an oversampling tick input, and the tick rate is chosen as 8, 16 or 32 pulses per bit. Each frame is a low start bit, eight data bits sent least significant first, and one or two high stop bits. The final stop bit can be trimmed one tick at a time through a 4-bit trim code, so that a following frame can begin a fraction of a bit earlier.

The byte arrives through a valid/ready handshake. The oversampling select, the trim code and the stop-count select are taken when a frame begins. A byte offered during the final stop bit is held in a one-entry slot, and its start bit follows the trimmed stop bit on the very next tick. A trim code that the current oversampling select does not allow is replaced by the full-length code, and a flag shows that the live settings are not valid.

Top module: `uart_fstop_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd_o` is high, `busy_o` is low and `ready_o` is high.
- R2: A frame is a start bit at 0, then `data_i[0]` through `data_i[7]`, then stop bits at 1. Every bit except the final stop bit lasts T ticks. T is 8 for `mode_i`=00, 16 for 01 and 32 for 10.
- R3: With `two_stop_i`=1 a frame has two stop bits. With `two_stop_i`=0 it has one.
- R4: In 16-tick mode, trim codes 8 to 15 give a final stop bit of T-15+code ticks, which is 9 to 16 ticks.
- R5: In 32-tick mode, every trim code 0 to 15 is valid and gives T-15+code ticks, which is 17 to 32 ticks.
- R6: In 8-tick mode, trim codes 12 to 15 give T-15+code ticks, which is 5 to 8 ticks.
- R7: A trim code below 12 in 8-tick mode, or below 8 in 16-tick mode, acts as code 15. `mode_i`=11 acts as 16-tick mode with code 15. `cfg_err_o` is high while the present `mode_i`/`fstop_i` pair is one of these cases, and low otherwise.
- R8: With two stop bits, only the second stop bit is trimmed. The first lasts T ticks.
- R9: `ready_o` is low from the start bit until the final stop bit begins. A `valid_i` in that span is ignored and does not change the frame in progress.
- R10: A byte accepted during the final stop bit starts its start bit on the tick right after that stop bit ends. `busy_o` stays high across the boundary and no idle time is inserted.
- R11: `mode_i`, `fstop_i` and `two_stop_i` are sampled when a frame begins. Changes to them during the frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, one pulse per sub-bit period |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | A byte is offered |
| ready_o | output | 1 | A byte can be taken in this cycle |
| mode_i | input | 2 | Ticks per bit: 00=8, 01=16, 10=32, 11=invalid |
| fstop_i | input | 4 | Trim code for the final stop bit |
| two_stop_i | input | 1 | 1 selects two stop bits |
| txd_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | A frame is in progress |
| cfg_err_o | output | 1 | The live mode and trim code form an invalid pair |

## Verification
The line is recorded once per tick and compared with a pattern the bench builds itself. Frames are sent in all three oversampling modes, at the minimum, middle and maximum valid trim codes, with invalid codes, and with one and two stop bits. Bytes such as 0x01, 0x80, 0xA5 and 0x5A separate bit order errors from timing errors. Comparing one- and two-stop frames that use the same code shows whether the trim lands only on the last stop bit. A chained pair of frames, with the settings scrambled in the middle of a frame and a byte offered while `ready_o` is low, tests the hand-off without idle time and the rule that settings are taken at frame start.

// File: rtl/uart_fstop_pkg.sv
package uart_fstop_pkg;
  localparam int OSR_LOG_MIN = 3;                      // 8 ticks per bit minimum
  localparam int FSB_W       = 4;
  localparam int MAX_TPB     = 1 << (OSR_LOG_MIN + 2);
  localparam int CNT_W       = $clog2(MAX_TPB + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_LAST
  } tx_state_e;
endpackage

// File: rtl/uart_fstop_cfg.sv
module uart_fstop_cfg
  import uart_fstop_pkg::*;
(
  input  logic [1:0]       mode_i,
  input  logic [FSB_W-1:0] code_i,
  output logic [CNT_W-1:0] tpb_o,
  output logic [CNT_W-1:0] last_o,
  output logic             err_o
);
  localparam int FULL = (1 << FSB_W) - 1;

  int  tpb;
  int  min_code;
  int  eff;
  logic mode_ok, code_ok;

  always_comb begin
    mode_ok  = (mode_i != 2'b11);
    tpb      = mode_ok ? (1 << (OSR_LOG_MIN + int'(mode_i))) : (1 << (OSR_LOG_MIN + 1));
    // lowest code that keeps the last stop bit longer than half a bit
    min_code = FULL + 1 - tpb / 2;
    code_ok  = mode_ok && (int'(code_i) >= min_code);
    eff      = code_ok ? int'(code_i) : FULL;
    tpb_o    = CNT_W'(tpb);
    last_o   = CNT_W'(tpb - FULL + eff);
    err_o    = !code_ok;
  end
endmodule

// File: rtl/uart_fstop_timer.sv
module uart_fstop_timer
  import uart_fstop_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = en_i && tick_i && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (done_o)    cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/uart_fstop_tx.sv
module uart_fstop_tx
  import uart_fstop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [1:0]        mode_i,
  input  logic [FSB_W-1:0]  fstop_i,
  input  logic              two_stop_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              cfg_err_o
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  tpb_q, last_q, tpb_d, last_d, limit;
  logic              two_q, pend_v_q;
  logic [DATA_W-1:0] pend_q;
  logic              done, accept;

  uart_fstop_cfg u_cfg (
    .mode_i (mode_i),
    .code_i (fstop_i),
    .tpb_o  (tpb_d),
    .last_o (last_d),
    .err_o  (cfg_err_o)
  );

  assign busy_o  = (state_q != ST_IDLE);
  assign ready_o = (state_q == ST_IDLE) || (state_q == ST_LAST && !pend_v_q);
  assign accept  = valid_i && ready_o;
  assign limit   = (state_q == ST_LAST) ? last_q : tpb_q;

  uart_fstop_timer u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (busy_o),
    .tick_i  (tick_i),
    .limit_i (limit),
    .done_o  (done)
  );

  always_comb begin
    unique case (state_q)
      ST_START: txd_o = 1'b0;
      ST_DATA:  txd_o = shreg_q[0];
      default:  txd_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      shreg_q  <= '0;
      idx_q    <= '0;
      tpb_q    <= '0;
      last_q   <= '0;
      two_q    <= 1'b0;
      pend_v_q <= 1'b0;
      pend_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          shreg_q <= data_i;
          tpb_q   <= tpb_d;
          last_q  <= last_d;
          two_q   <= two_stop_i;
          state_q <= ST_START;
        end
        ST_START: if (done) begin
          idx_q   <= '0;
          state_q <= ST_DATA;
        end
        ST_DATA: if (done) begin
          shreg_q <= shreg_q >> 1;
          if (idx_q == IDX_W'(DATA_W - 1)) state_q <= two_q ? ST_STOP : ST_LAST;
          else                             idx_q   <= idx_q + IDX_W'(1);
        end
        ST_STOP: if (done) state_q <= ST_LAST;
        ST_LAST: begin
          if (done) begin
            if (pend_v_q || accept) begin
              // next frame begins at once; settings taken now
              shreg_q  <= pend_v_q ? pend_q : data_i;
              tpb_q    <= tpb_d;
              last_q   <= last_d;
              two_q    <= two_stop_i;
              pend_v_q <= 1'b0;
              state_q  <= ST_START;
            end else begin
              state_q <= ST_IDLE;
            end
          end else if (accept) begin
            pend_v_q <= 1'b1;
            pend_q   <= data_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_fstop_tx_chk.sv
module uart_fstop_tx_chk
  import uart_fstop_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             valid_i,
  input logic             ready_o,
  input logic             txd_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] tpb_q,
  input logic [CNT_W-1:0] last_q
);
  assert_idle_line_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (txd_o && ready_o));

  assert_frame_opens_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(busy_o)) |-> (!txd_o && $past(valid_i && ready_o)));

  assert_line_moves_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && (txd_o != $past(txd_o))) |-> $past(tick_i));

  assert_ready_only_in_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ready_o) |-> txd_o);

  assert_last_len_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ((last_q <= tpb_q) && (last_q > (tpb_q >> 1))));

  assert_cfg_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(tick_i)) |-> ($stable(tpb_q) && $stable(last_q)));
endmodule

bind uart_fstop_tx uart_fstop_tx_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .txd_o   (txd_o),
  .busy_o  (busy_o),
  .tpb_q   (tpb_q),
  .last_q  (last_q)
);

// File: tb/uart_fstop_tx_tb.sv
module uart_fstop_tx_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       valid_i = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic [3:0] fstop_i = 4'hF;
  logic       two_stop_i = 1'b0;
  logic       ready_o, txd_o, busy_o, cfg_err_o;

  int n_run = 0, n_fail = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  uart_fstop_tx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .data_i(data_i), .valid_i(valid_i),
    .ready_o(ready_o), .mode_i(mode_i), .fstop_i(fstop_i), .two_stop_i(two_stop_i),
    .txd_o(txd_o), .busy_o(busy_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tpb_of(input logic [1:0] m);
    return (m == 2'b11) ? 16 : (8 << m);
  endfunction

  function automatic bit code_valid(input logic [1:0] m, input logic [3:0] c);
    case (m)
      2'b00:   return c >= 12;
      2'b01:   return c >= 8;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int last_of(input logic [1:0] m, input logic [3:0] c);
    return tpb_of(m) - 15 + (code_valid(m, c) ? int'(c) : 15);
  endfunction

  // Sends one frame tick by tick and compares the line against the expected pattern.
  task automatic run_frame(input logic [1:0] m, input logic [3:0] c, input bit two,
                           input logic [7:0] d, input bit preacc, input bit chain,
                           input logic [1:0] m2, input logic [3:0] c2, input bit two2,
                           input logic [7:0] d2, input string req);
    int t, l, total, mism, first_bad, stop_ready;
    bit exp_bit;
    t = tpb_of(m);
    l = last_of(m, c);
    total = 9 * t + (two ? t : 0) + l;
    mism = 0; first_bad = -1; stop_ready = 1;
    if (!preacc) begin
      @(negedge clk);
      mode_i = m; fstop_i = c; two_stop_i = two; data_i = d; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0; data_i = 8'h00;
    end
    for (int k = 0; k < total; k++) begin
      if (k < t)          exp_bit = 1'b0;
      else if (k < 9 * t) exp_bit = d[(k - t) / t];
      else                exp_bit = 1'b1;
      if (txd_o !== exp_bit) begin
        mism++;
        if (first_bad < 0) first_bad = k;
      end
      if (k == 0) begin // scramble settings mid-frame (R11)
        mode_i = m ^ 2'b01; fstop_i = ~c; two_stop_i = ~two;
      end
      if (k < total - l) begin
        if (ready_o !== 1'b0) stop_ready = 0;
        valid_i = 1'b1; data_i = 8'hFF;      // ignored offer (R9)
      end
      if (k == total - l) begin
        if (ready_o !== 1'b1) stop_ready = 0;
        if (chain) begin
          mode_i = m2; fstop_i = c2; two_stop_i = two2; data_i = d2; valid_i = 1'b1;
        end
      end
      if (k == total - 1) chk(busy_o === 1'b1, {req, " busy before last tick"}, busy_o, 1);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0; valid_i = 1'b0;
      @(negedge clk);
    end
    chk(mism == 0, {req, " line pattern"}, first_bad, -1);
    chk(stop_ready == 1, {req, " R9 ready window"}, stop_ready, 1);
    if (chain) chk(busy_o === 1'b1 && txd_o === 1'b0, {req, " R10 no idle gap"}, txd_o, 0);
    else       chk(busy_o === 1'b0 && txd_o === 1'b1, {req, " frame ends"}, busy_o, 0);
  endtask

  typedef struct packed {
    logic [1:0] m;
    logic [3:0] c;
    logic       two;
    logic [7:0] d;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 4'hF, 1'b0, 8'hA5},  // R2 R4 16x full
    '{2'b01, 4'h8, 1'b0, 8'h01},  // R4 16x shortest
    '{2'b01, 4'hB, 1'b0, 8'h80},  // R4 middle
    '{2'b10, 4'hF, 1'b0, 8'h5A},  // R5 32x full
    '{2'b10, 4'h0, 1'b0, 8'hC3},  // R5 32x shortest
    '{2'b10, 4'h6, 1'b1, 8'h3C},  // R5 R8 two stops
    '{2'b00, 4'hF, 1'b0, 8'hF0},  // R6 8x full
    '{2'b00, 4'hC, 1'b0, 8'h0F},  // R6 8x shortest
    '{2'b00, 4'hD, 1'b1, 8'h96},  // R6 R8 R3
    '{2'b01, 4'h9, 1'b1, 8'h69},  // R3 R8 16x two stops
    '{2'b00, 4'hB, 1'b0, 8'h55},  // R7 8x invalid code -> full
    '{2'b01, 4'h3, 1'b0, 8'hAA},  // R7 16x invalid code -> full
    '{2'b11, 4'h9, 1'b0, 8'h77},  // R7 invalid mode
    '{2'b00, 4'h8, 1'b1, 8'hE1}   // R7 R8 8x invalid two stops
  };

  task automatic cfg_err_check(input logic [1:0] m, input logic [3:0] c);
    @(negedge clk);
    mode_i = m; fstop_i = c;
    #1;
    chk(cfg_err_o === !code_valid(m, c), "R7 cfg_err_o", cfg_err_o, !code_valid(m, c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd_o === 1'b1, "R1 txd after reset", txd_o, 1);
    chk(busy_o === 1'b0, "R1 busy after reset", busy_o, 0);
    chk(ready_o === 1'b1, "R1 ready after reset", ready_o, 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd_o === 1'b1 && busy_o === 1'b0, "R1 idle after release", txd_o, 1);

    for (int i = 0; i < NV; i++)
      run_frame(VECS[i].m, VECS[i].c, VECS[i].two, VECS[i].d, 1'b0, 1'b0,
                2'b00, 4'h0, 1'b0, 8'h00, $sformatf("R2 vec%0d", i));

    // R10 chained frames with shortened stops, settings changed at the hand-off
    run_frame(2'b01, 4'h8, 1'b0, 8'h4D, 1'b0, 1'b1, 2'b00, 4'hC, 1'b1, 8'hB2, "R10 chain A");
    run_frame(2'b00, 4'hC, 1'b1, 8'hB2, 1'b1, 1'b1, 2'b10, 4'h1, 1'b0, 8'h17, "R10 chain B");
    run_frame(2'b10, 4'h1, 1'b0, 8'h17, 1'b1, 1'b0, 2'b00, 4'h0, 1'b0, 8'h00, "R11 chain C");

    // R1 idle stays idle after chain, no stray frame from ignored offers (R9)
    repeat (20) begin
      @(negedge clk); tick_i = 1'b1; @(negedge clk); tick_i = 1'b0;
    end
    chk(busy_o === 1'b0 && txd_o === 1'b1, "R9 no stray frame", busy_o, 0);

    // R7 flag over the live inputs
    cfg_err_check(2'b00, 4'hC);
    cfg_err_check(2'b00, 4'hB);
    cfg_err_check(2'b01, 4'h8);
    cfg_err_check(2'b01, 4'h7);
    cfg_err_check(2'b10, 4'h0);
    cfg_err_check(2'b11, 4'hF);

    // R1 reset in mid-frame returns to idle
    @(negedge clk);
    mode_i = 2'b00; fstop_i = 4'hF; data_i = 8'h00; valid_i = 1'b1;
    @(negedge clk); valid_i = 1'b0;
    chk(busy_o === 1'b1 && txd_o === 1'b0, "R2 start bit drives low", txd_o, 0);
    rst_ni = 1'b0;
    #1;
    chk(busy_o === 1'b0 && txd_o === 1'b1 && ready_o === 1'b1, "R1 async reset", busy_o, 0);
    @(negedge clk); rst_ni = 1'b1;

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule